// File: doc/BRIEF.md
# General-Purpose Timer with Compare, Capture and Waveform Output

This block is a general-purpose up-counting timer driven by a single functional clock and programmed over a simple synchronous register bus. One control word configures all of its options:

- counting can run on every clock or on a power-of-two prescaled tick;
- an overflow either wraps and halts the timer, or reloads a preset value and keeps counting;
- a compare register flags the tick on which the count reaches it;
- a synchronised external input can latch the running count on a chosen edge;
- a waveform pin can toggle, or emit a one-tick pulse, on overflow alone or on overflow and compare.

The block holds three event flags: compare, overflow and capture. Each is cleared by writing a one to it. Two independent masks route the flags to an interrupt line and to a wake line.

Software typically loads the reload and compare values, writes the counter or strobes the reload register, and then sets the run bit. It reads the counter, the capture register and the flags on the same bus. Bus addresses are byte offsets of 32-bit words.

Top module: `gpt_core`

## Requirements
- R1: After synchronous reset every register reads 0, and `irq`, `wake` and `tmr_out` are 0.
- R2: While control bit 0 (run) is 1, the counter advances by one per tick. With control bit 5 clear, a tick occurs every clock. With bit 5 set, a tick occurs every 2^(P+1) clocks, where P is control bits 4:2.
- R3: A tick at count 0xFFFFFFFF sets flag bit 1. If control bit 1 is set, the counter then takes the reload register (offset 0x2C). Otherwise the counter wraps to 0 and the run bit clears itself.
- R4: A write to the counter (offset 0x28) sets the count. A write of any data to the strobe offset 0x30 copies the reload register into the counter. Either write wins over a tick in the same cycle.
- R5: With control bit 6 set, a tick that moves the count onto the compare register (offset 0x38) sets flag bit 0. With bit 6 clear, the compare flag never sets.
- R6: `cap_in` passes through two synchroniser flops. Control bits 9:8 select the capture edge: 00 none, 01 rising, 10 falling, 11 both. A selected edge copies the count into the capture register (offset 0x3C) and sets flag bit 2.
- R7: With control bit 13 set, a capture happens only while flag bit 2 is clear.
- R8: Flags read at offset 0x18 with bit 0 compare, bit 1 overflow and bit 2 capture. Writing a 1 clears a flag, and a new event in the same cycle wins. `irq` is the OR of the flags masked by offset 0x1C, and `wake` is the OR masked by offset 0x20. Both are registered one cycle after the flags.
- R9: Control bits 11:10 choose the output trigger: 00 none (state cleared), 01 overflow, 10 overflow or compare. With bit 12 set, each trigger flips the output state. With bit 12 clear, the state is high for one tick after a trigger. `tmr_out` is control bit 7 XOR the state, registered.
- R10: `tmr_out_en` is the inverse of control bit 14, registered.
- R11: Once the run bit is cleared, the count holds from the next cycle and the prescaler restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, registered one cycle after the read |
| cap_in | input | 1 | Asynchronous capture input |
| tmr_out | output | 1 | Waveform output |
| tmr_out_en | output | 1 | Drive enable for the waveform pin |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request |

## Verification
Counting is exercised in four ways:

- free-running;
- prescaled;
- with an overflow that halts;
- with an overflow that reloads.

These separate the tick generation from the wrap policy. A bus write is issued on a running counter to show that the write beats the tick.

Capture is driven with rising and falling edges under each edge selection and under first-only mode. This tells apart the edge decoding from the pending-flag gate.

The waveform output is run with a short reload period in toggle mode, pulse mode and compare-trigger mode. Each of these gives a different output sequence against the cycle model.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  localparam int PRE_W = 3;

  localparam int OFF_STAT  = 'h18;
  localparam int OFF_IEN   = 'h1C;
  localparam int OFF_WEN   = 'h20;
  localparam int OFF_CTRL  = 'h24;
  localparam int OFF_CNT   = 'h28;
  localparam int OFF_LOAD  = 'h2C;
  localparam int OFF_STRB  = 'h30;
  localparam int OFF_CMP   = 'h38;
  localparam int OFF_CAP   = 'h3C;

  localparam int FLG_CMP = 0;
  localparam int FLG_OVF = 1;
  localparam int FLG_CAP = 2;

  typedef struct packed {
    logic             pin_in;
    logic             cap_first;
    logic             toggle;
    logic [1:0]       trig;
    logic [1:0]       edge_sel;
    logic             def_lvl;
    logic             cmp_en;
    logic             pre_en;
    logic [PRE_W-1:0] pre_val;
    logic             reload;
    logic             run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/gpt_prescale.sv
module gpt_prescale
  import gpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pre_en,
  input  logic [PRE_W-1:0] pre_val,
  output logic             tick
);
  localparam int PCNT_W = 1 << PRE_W;

  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] limit;

  assign limit = {PCNT_W{1'b1}} >> (PCNT_W - 1 - int'(pre_val));
  assign tick  = run && (!pre_en || pcnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) pcnt_q <= '0;
    else if (pre_en)         pcnt_q <= pcnt_q + 1'b1;
  end

  AST_PRE_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && pre_en) |=> (!tick || !pre_en)); // R2

endmodule

// File: rtl/gpt_capture.sv
module gpt_capture (
  input  logic       clk,
  input  logic       rst,
  input  logic       cap_in,
  input  logic [1:0] edge_sel,
  input  logic       first_only,
  input  logic       pend,
  output logic       cap_evt
);
  logic [2:0] sync_q;
  logic       rise, fall, hit;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], cap_in};
  end

  assign rise = sync_q[1] && !sync_q[2];
  assign fall = !sync_q[1] && sync_q[2];

  always_comb begin
    unique case (edge_sel)
      2'b01:   hit = rise;
      2'b10:   hit = fall;
      2'b11:   hit = rise || fall;
      default: hit = 1'b0;
    endcase
  end

  assign cap_evt = hit && !(first_only && pend);

endmodule

// File: rtl/gpt_outgen.sv
module gpt_outgen (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       adv,
  input  logic       ovf,
  input  logic       mat,
  input  logic [1:0] trig,
  input  logic       toggle,
  input  logic       def_lvl,
  input  logic       pin_in,
  output logic       out_o,
  output logic       oe_o
);
  logic st_q;
  logic evt;

  assign evt = (trig == 2'b01 && ovf) || (trig == 2'b10 && (ovf || mat));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= 1'b0;
      out_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      if (trig == 2'b00)     st_q <= 1'b0;
      else if (toggle)       st_q <= st_q ^ evt;
      else if (adv || !run)  st_q <= evt;
      out_o <= def_lvl ^ st_q;
      oe_o  <= !pin_in;
    end
  end

  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
    (!toggle && trig != 2'b00 && st_q && adv && !evt) |=> !st_q); // R9

endmodule

// File: rtl/gpt_core.sv
module gpt_core
  import gpt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              cap_in,
  output logic              tmr_out,
  output logic              tmr_out_en,
  output logic              irq,
  output logic              wake
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q, load_q, cmp_q, cap_q, cnt_nxt;
  logic [2:0]       stat_q, ien_q, wen_q, stat_set, stat_clr;
  logic             bw, br, wr_ctrl, wr_cnt, wr_strb, cnt_bus;
  logic             tick, adv, ovf_evt, mat_evt, cap_evt;

  assign bw      = bus_sel && bus_wr;
  assign br      = bus_sel && !bus_wr;
  assign wr_ctrl = bw && bus_addr == ADDR_W'(OFF_CTRL);
  assign wr_cnt  = bw && bus_addr == ADDR_W'(OFF_CNT);
  assign wr_strb = bw && bus_addr == ADDR_W'(OFF_STRB);
  assign cnt_bus = wr_cnt || wr_strb;

  gpt_prescale u_pre (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .pre_en(ctrl_q.pre_en),
    .pre_val(ctrl_q.pre_val), .tick(tick)
  );

  assign adv     = tick && !cnt_bus;
  assign ovf_evt = adv && cnt_q == CNT_MAX;
  assign cnt_nxt = (cnt_q == CNT_MAX) ? (ctrl_q.reload ? load_q : '0) : cnt_q + 1'b1;
  assign mat_evt = adv && ctrl_q.cmp_en && cnt_nxt == cmp_q;

  gpt_capture u_cap (
    .clk(clk), .rst(rst), .cap_in(cap_in), .edge_sel(ctrl_q.edge_sel),
    .first_only(ctrl_q.cap_first), .pend(stat_q[FLG_CAP]), .cap_evt(cap_evt)
  );

  gpt_outgen u_out (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .adv(adv), .ovf(ovf_evt),
    .mat(mat_evt), .trig(ctrl_q.trig), .toggle(ctrl_q.toggle),
    .def_lvl(ctrl_q.def_lvl), .pin_in(ctrl_q.pin_in),
    .out_o(tmr_out), .oe_o(tmr_out_en)
  );

  always_comb begin
    stat_set          = '0;
    stat_set[FLG_CMP] = mat_evt;
    stat_set[FLG_OVF] = ovf_evt;
    stat_set[FLG_CAP] = cap_evt;
    stat_clr = (bw && bus_addr == ADDR_W'(OFF_STAT)) ? bus_wdata[2:0] : 3'b000;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      load_q <= '0;
      cmp_q  <= '0;
      cap_q  <= '0;
      stat_q <= '0;
      ien_q  <= '0;
      wen_q  <= '0;
      irq    <= 1'b0;
      wake   <= 1'b0;
    end else begin
      if (wr_ctrl)                       ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      else if (ovf_evt && !ctrl_q.reload) ctrl_q.run <= 1'b0;

      if (wr_cnt)       cnt_q <= bus_wdata;
      else if (wr_strb) cnt_q <= load_q;
      else if (adv)     cnt_q <= cnt_nxt;

      if (bw && bus_addr == ADDR_W'(OFF_LOAD)) load_q <= bus_wdata;
      if (bw && bus_addr == ADDR_W'(OFF_CMP))  cmp_q  <= bus_wdata;
      if (bw && bus_addr == ADDR_W'(OFF_IEN))  ien_q  <= bus_wdata[2:0];
      if (bw && bus_addr == ADDR_W'(OFF_WEN))  wen_q  <= bus_wdata[2:0];
      if (cap_evt) cap_q <= cnt_q;

      stat_q <= (stat_q & ~stat_clr) | stat_set;
      irq    <= |(stat_q & ien_q);
      wake   <= |(stat_q & wen_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (br) begin
      case (bus_addr)
        ADDR_W'(OFF_STAT): bus_rdata <= CNT_W'(stat_q);
        ADDR_W'(OFF_IEN):  bus_rdata <= CNT_W'(ien_q);
        ADDR_W'(OFF_WEN):  bus_rdata <= CNT_W'(wen_q);
        ADDR_W'(OFF_CTRL): bus_rdata <= CNT_W'(ctrl_q);
        ADDR_W'(OFF_CNT):  bus_rdata <= cnt_q;
        ADDR_W'(OFF_LOAD): bus_rdata <= load_q;
        ADDR_W'(OFF_CMP):  bus_rdata <= cmp_q;
        ADDR_W'(OFF_CAP):  bus_rdata <= cap_q;
        default:           bus_rdata <= '0;
      endcase
    end
  end

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (bw && bus_addr == ADDR_W'(OFF_STAT) && bus_wdata[FLG_OVF] && !ovf_evt) |=> !stat_q[FLG_OVF]); // R8
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (|(stat_q & ien_q)) |=> irq); // R8
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && !cnt_bus) |=> $stable(cnt_q)); // R11
  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && ctrl_q.reload) |=> cnt_q == $past(load_q)); // R3
  AST_OVF_HALT: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && !ctrl_q.reload && !wr_ctrl) |=> !ctrl_q.run); // R3
  AST_CAP_LATCH: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (stat_q[FLG_CAP] && cap_q == $past(cnt_q))); // R6

endmodule

// File: tb/gpt_core_tb.sv
module gpt_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, cap_in = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tmr_out, tmr_out_en, irq, wake;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gpt_core u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .tmr_out(tmr_out), .tmr_out_en(tmr_out_en),
    .irq(irq), .wake(wake)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_cnt, m_load, m_cmp, m_cap, m_rd;
  logic [14:0] m_ctrl;
  logic [2:0]  m_stat, m_ien, m_wen;
  int          m_pcnt;
  logic        m_s1, m_s2, m_s3, m_st, m_out, m_oe, m_irq, m_wake;

  always @(posedge clk) begin : model
    int          lim;
    logic        run, tick, adv, ovf, mat, cev, hit, oev, bwr, cbus, rise, fall;
    logic [31:0] nxt;
    logic [2:0]  clr;
    if (rst) begin
      m_cnt = 0; m_load = 0; m_cmp = 0; m_cap = 0; m_rd = 0; m_ctrl = 0;
      m_stat = 0; m_ien = 0; m_wen = 0; m_pcnt = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_st = 0; m_out = 0; m_oe = 0; m_irq = 0; m_wake = 0;
    end else begin
      run  = m_ctrl[0];
      bwr  = bus_sel && bus_wr;
      cbus = bwr && (bus_addr == 8'h28 || bus_addr == 8'h30);
      lim  = (1 << (int'(m_ctrl[4:2]) + 1)) - 1;
      tick = run && (!m_ctrl[5] || m_pcnt == lim);
      adv  = tick && !cbus;
      ovf  = adv && m_cnt == 32'hFFFF_FFFF;
      nxt  = (m_cnt == 32'hFFFF_FFFF) ? (m_ctrl[1] ? m_load : 32'h0) : m_cnt + 1;
      mat  = adv && m_ctrl[6] && nxt == m_cmp;
      rise = m_s2 && !m_s3;
      fall = !m_s2 && m_s3;
      hit  = (m_ctrl[9:8] == 2'd1 && rise) || (m_ctrl[9:8] == 2'd2 && fall) ||
             (m_ctrl[9:8] == 2'd3 && (rise || fall));
      cev  = hit && !(m_ctrl[13] && m_stat[2]);
      oev  = (m_ctrl[11:10] == 2'd1 && ovf) || (m_ctrl[11:10] == 2'd2 && (ovf || mat));
      if (bus_sel && !bus_wr) begin
        case (bus_addr)
          8'h18: m_rd = {29'b0, m_stat};
          8'h1C: m_rd = {29'b0, m_ien};
          8'h20: m_rd = {29'b0, m_wen};
          8'h24: m_rd = {17'b0, m_ctrl};
          8'h28: m_rd = m_cnt;
          8'h2C: m_rd = m_load;
          8'h38: m_rd = m_cmp;
          8'h3C: m_rd = m_cap;
          default: m_rd = 0;
        endcase
      end
      m_irq  = |(m_stat & m_ien);
      m_wake = |(m_stat & m_wen);
      m_out  = m_ctrl[7] ^ m_st;
      m_oe   = !m_ctrl[14];
      if (m_ctrl[11:10] == 2'd0) m_st = 0;
      else if (m_ctrl[12])       m_st = m_st ^ oev;
      else if (adv || !run)      m_st = oev;
      if (!run || tick) m_pcnt = 0;
      else if (m_ctrl[5]) m_pcnt = (m_pcnt + 1) & 255;
      if (cev) m_cap = m_cnt;
      clr = (bwr && bus_addr == 8'h18) ? bus_wdata[2:0] : 3'b0;
      m_stat = (m_stat & ~clr) | {cev, ovf, mat};
      if (bwr && bus_addr == 8'h28)      m_cnt = bus_wdata;
      else if (bwr && bus_addr == 8'h30) m_cnt = m_load;
      else if (adv)                      m_cnt = nxt;
      if (bwr && bus_addr == 8'h24)      m_ctrl = bus_wdata[14:0];
      else if (ovf && !m_ctrl[1])        m_ctrl[0] = 1'b0;
      if (bwr && bus_addr == 8'h2C) m_load = bus_wdata;
      if (bwr && bus_addr == 8'h38) m_cmp  = bus_wdata;
      if (bwr && bus_addr == 8'h1C) m_ien  = bus_wdata[2:0];
      if (bwr && bus_addr == 8'h20) m_wen  = bus_wdata[2:0];
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 R4 model bus_rdata", bus_rdata, m_rd);
      chk("R8 model irq", {31'b0, irq}, {31'b0, m_irq});
      chk("R8 model wake", {31'b0, wake}, {31'b0, m_wake});
      chk("R9 model tmr_out", {31'b0, tmr_out}, {31'b0, m_out});
      chk("R10 model tmr_out_en", {31'b0, tmr_out_en}, {31'b0, m_oe});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; v = bus_rdata;
  endtask

  task automatic cap_to(input logic lvl);
    @(negedge clk); cap_in = lvl;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    logic [31:0] v, v1;
    int          toggles, hi_run, max_run, pulses;
    logic        prev;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tmr_out", {31'b0, tmr_out}, 0);
    rd(8'h24, v); chk("R1 ctrl", v, 0);
    rd(8'h28, v); chk("R1 counter", v, 0);
    rd(8'h18, v); chk("R1 flags", v, 0);
    // R4 direct write and strobe reload
    wr(8'h2C, 32'h100);
    wr(8'h28, 32'h55); rd(8'h28, v); chk("R4 counter write", v, 32'h55);
    wr(8'h30, 32'hDEAD); rd(8'h28, v); chk("R4 strobe reload", v, 32'h100);
    // R2 free running, R11 stop holds
    wr(8'h28, 0); wr(8'h24, 1); repeat (10) @(negedge clk); wr(8'h24, 0);
    rd(8'h28, v); chk("R2 free count", v, 12);
    repeat (5) @(negedge clk);
    rd(8'h28, v); chk("R11 held after stop", v, 12);
    // R2 prescaled period 4
    wr(8'h28, 0); wr(8'h24, 32'h25); repeat (10) @(negedge clk); wr(8'h24, 0);
    rd(8'h28, v); chk("R2 prescaled count", v, 3);
    // R4 bus write beats tick
    wr(8'h24, 1); wr(8'h28, 32'h40); wr(8'h24, 0);
    rd(8'h28, v); chk("R4 write wins over tick", v, 32'h42);
    // R3 overflow without reload
    wr(8'h18, 7); wr(8'h28, 32'hFFFF_FFFE); wr(8'h24, 1); repeat (5) @(negedge clk);
    rd(8'h24, v); chk("R3 run self-clears", v, 0);
    rd(8'h28, v); chk("R3 wraps to zero", v, 0);
    rd(8'h18, v); chk("R3 overflow flag", v, 2);
    // R8 masks and write-one-to-clear
    wr(8'h1C, 2); repeat (3) @(negedge clk);
    chk("R8 irq asserted", {31'b0, irq}, 1);
    chk("R8 wake masked", {31'b0, wake}, 0);
    wr(8'h20, 2); repeat (3) @(negedge clk);
    chk("R8 wake asserted", {31'b0, wake}, 1);
    wr(8'h18, 0); rd(8'h18, v); chk("R8 zero write keeps flag", v, 2);
    wr(8'h18, 2); repeat (3) @(negedge clk);
    chk("R8 irq released", {31'b0, irq}, 0);
    rd(8'h18, v); chk("R8 flag cleared", v, 0);
    // R3 overflow with reload
    wr(8'h2C, 32'h10); wr(8'h28, 32'hFFFF_FFFF); wr(8'h24, 3); wr(8'h24, 0);
    rd(8'h28, v); chk("R3 reload value", v, 32'h11);
    rd(8'h18, v); chk("R3 overflow flag on reload", v, 2);
    // R5 compare
    wr(8'h18, 7); wr(8'h28, 0); wr(8'h38, 5); wr(8'h24, 32'h41);
    repeat (10) @(negedge clk); wr(8'h24, 0);
    rd(8'h18, v); chk("R5 compare flag", v & 1, 1);
    wr(8'h18, 7); wr(8'h28, 0); wr(8'h24, 1);
    repeat (10) @(negedge clk); wr(8'h24, 0);
    rd(8'h18, v); chk("R5 compare disabled", v, 0);
    // R6 capture edges
    wr(8'h18, 7); wr(8'h24, 32'h101);
    cap_to(1); rd(8'h18, v); chk("R6 rising capture", v & 4, 4);
    rd(8'h3C, v);
    wr(8'h18, 4); cap_to(0); rd(8'h18, v); chk("R6 falling ignored in rise mode", v & 4, 0);
    wr(8'h24, 32'h301); cap_to(1); rd(8'h18, v); chk("R6 both edges", v & 4, 4);
    wr(8'h24, 32'h001); wr(8'h18, 4); cap_to(0); cap_to(1);
    rd(8'h18, v); chk("R6 no edge selected", v & 4, 0);
    // R7 first-only capture
    cap_to(0); wr(8'h18, 7); wr(8'h24, 32'h2101);
    cap_to(1); cap_to(0); rd(8'h3C, v1);
    cap_to(1); rd(8'h3C, v); chk("R7 second edge ignored", v, v1);
    wr(8'h24, 0); cap_to(0);
    // R9 toggle on overflow
    wr(8'h2C, 32'hFFFF_FFFC); wr(8'h28, 32'hFFFF_FFFC); wr(8'h24, 32'h1403);
    toggles = 0; prev = tmr_out;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); if (tmr_out != prev) toggles++; prev = tmr_out;
    end
    chk("R9 toggles seen", (toggles >= 8) ? 1 : 0, 1);
    // R9 pulse on overflow
    wr(8'h24, 32'h0403); repeat (4) @(negedge clk);
    hi_run = 0; max_run = 0; pulses = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tmr_out) begin hi_run++; if (hi_run == 1) pulses++; end else hi_run = 0;
      if (hi_run > max_run) max_run = hi_run;
    end
    chk("R9 pulse width one tick", max_run, 1);
    chk("R9 pulses seen", (pulses >= 8) ? 1 : 0, 1);
    // R9 compare trigger, checked by the model
    wr(8'h38, 32'hFFFF_FFFD); wr(8'h24, 32'h1843); repeat (30) @(negedge clk);
    // R9 default level
    wr(8'h24, 32'h80); repeat (3) @(negedge clk);
    chk("R9 default level high", {31'b0, tmr_out}, 1);
    // R10 pin direction
    wr(8'h24, 32'h4000); repeat (3) @(negedge clk);
    chk("R10 drive disabled", {31'b0, tmr_out_en}, 0);
    wr(8'h24, 0); repeat (3) @(negedge clk);
    chk("R10 drive enabled", {31'b0, tmr_out_en}, 1);
    finish_run();
  end

endmodule